// File: doc/BRIEF.md
# NAND Transfer Counter and Interrupt Unit

This unit sits between the byte-wide data path of a NAND flash controller and a word-wide streaming port served by an external DMA master. Software programs a transfer direction, an optional burst mode and a byte count, then sets the start bit. Bytes then move one at a time on the flash side and 32-bit words on the DMA side. The byte count falls by one for every byte moved and reads zero at the end. A small word FIFO and a byte packer/unpacker connect the two sides.

Request lines tell the DMA master when to move data. A burst request asks for four words. A single request asks for one word and is used for the tail of a transfer, or for every word when burst mode is off. Two interrupt sources are latched separately: the terminal count and a rising edge of the flash ready line. Each has its own enable bit and a write-one-to-clear bit, and the unit has one combined interrupt output. A software reset bit returns the unit to its idle state.

Top module: `nand_xfer_unit`

## Requirements
- R1: After reset every register reads 0, and `irq`, `dmaBurstReq`, `dmaSingleReq` and `eccClear` are low.
- R2: Register 0 (control). Bit 0 is the start bit and reads back. Writing 1 to bit 1 drives `eccClear` high for exactly the one cycle after the write. Writing 1 to bit 2 performs a software reset. Bits 1 and 2 read as 0.
- R3: Register 1 (configuration). Bit 1 sets the direction (0 = to the flash, 1 = from the flash), bit 2 enables burst requests and bit 4 enables the ECC during transfers. All three bits read back. `eccRun` is high while bit 4 and the start bit are both set.
- R4: Writing register 7 loads the byte count. While started, the count falls by one for each byte moved on the flash side. It reads 0 when the transfer ends, and no more flash-side bytes are accepted or offered after that.
- R5: In the read direction, bytes are packed into words with the first byte in bits 7:0. When the count reaches zero, a final partial word is pushed with its unused upper bytes set to zero. `dmaRdData` shows the oldest word, and `dmaRdPop` removes it.
- R6: In the write direction, each word pushed by the DMA master is sent to the flash lowest byte first. Bytes left over once the count reaches zero are discarded.
- R7: With burst mode on, `dmaBurstReq` is high when the FIFO holds at least 4 words (read), or when at least 4 words are free and at least 16 more bytes are still needed (write).
- R8: `dmaSingleReq` is high when there is no burst request and one word can move (a stored word on reads; a free slot plus needed bytes on writes). In burst mode this also requires fewer than 16 bytes to remain (read: count; write: needed bytes).
- R9: Register 2 (status). Bit 2 is set when the word FIFO is not empty, bit 1 when the packer or unpacker holds bytes, and bit 0 when the registered ready input is high.
- R10: Interrupt bit 1 (terminal count) latches when the count steps from 1 to 0 while started.
- R11: Interrupt bit 0 (ready) latches on a low-to-high change of `nandReady`.
- R12: Register 3 holds the latched bits, register 4 the enables and register 5 the latched bits ANDed with the enables. Writing 1s to register 6 clears those latched bits, and a new event in the same cycle wins over the clear. `irq` is high when any enabled latched bit is set.
- R13: A software reset clears the start bit, the configuration, the enables, the latched bits, the count, the FIFO, the packer and the unpacker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register word index |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data (combinational) |
| nandRdValid | input | 1 | Flash-side byte offered (read direction) |
| nandRdByte | input | 8 | Flash-side byte value |
| nandRdReady | output | 1 | Unit accepts the offered byte |
| nandWrValid | output | 1 | Unit offers a byte to the flash side |
| nandWrByte | output | 8 | Offered byte value |
| nandWrTake | input | 1 | Flash side takes the offered byte |
| nandReady | input | 1 | Flash ready line |
| dmaBurstReq | output | 1 | Four-word transfer requested |
| dmaSingleReq | output | 1 | One-word transfer requested |
| dmaRdPop | input | 1 | DMA master removes the head word |
| dmaRdData | output | 32 | Head word of the FIFO |
| dmaWrPush | input | 1 | DMA master pushes a word |
| dmaWrData | input | 32 | Pushed word |
| eccClear | output | 1 | One-cycle ECC clear pulse |
| eccRun | output | 1 | ECC enabled for the running transfer |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses the default eight-word FIFO and a 13-bit counter. With these values a 22-byte read fits in the FIFO without back-pressure, so the burst threshold, the switch to single requests below 16 bytes and the zero-padded final word can all be reached with short stimulus. A 6-byte write with burst mode off shows the discard of surplus bytes. A 20-byte burst write is stopped part-way by a software reset, which shows that the reset clears state in the middle of a transfer.

// File: rtl/nand_xfer_pkg.sv
`timescale 1ns/1ps
package nand_xfer_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CFG  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_IRAW = 3'd3;
  localparam logic [2:0] A_IEN  = 3'd4;
  localparam logic [2:0] A_IMSK = 3'd5;
  localparam logic [2:0] A_ICLR = 3'd6;
  localparam logic [2:0] A_TCNT = 3'd7;

  localparam int CTRL_START  = 0;
  localparam int CTRL_ECCCLR = 1;
  localparam int CTRL_SRST   = 2;
  localparam int CFG_DIR     = 1;
  localparam int CFG_BURST   = 2;
  localparam int CFG_ECCDMA  = 4;
  localparam int ST_READY    = 0;
  localparam int ST_CFIFO    = 1;
  localparam int ST_DFIFO    = 2;
  localparam int INT_RDY     = 0;
  localparam int INT_TC      = 1;

  typedef struct packed {
    logic flush;
    logic rdAccept;
    logic rdLast;
    logic rdPop;
    logic wrPush;
    logic wrLoad;
    logic wrTake;
    logic wrLast;
  } xferStrobes_t;
endpackage

// File: rtl/nand_xfer_datapath.sv
`timescale 1ns/1ps
module nand_xfer_datapath
  import nand_xfer_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rstN,
  input  xferStrobes_t   stb,
  input  logic [7:0]     rdByte,
  input  logic [31:0]    wrWord,
  output logic [31:0]    headWord,
  output logic [CW-1:0]  fifoCount,
  output logic [1:0]     packCnt,
  output logic [2:0]     unpackCnt,
  output logic [7:0]     unpackByte
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] cnt;
  logic [31:0]   packReg, packNext;
  logic [1:0]    packIdx;
  logic [31:0]   unpWord;
  logic [1:0]    unpIdx;
  logic [2:0]    unpCnt;
  logic          packDone, pushEn, popEn;
  logic [31:0]   pushData;

  always_comb begin
    packNext = packReg;
    packNext[8*packIdx +: 8] = rdByte;
  end

  assign packDone = stb.rdAccept && (packIdx == 2'd3 || stb.rdLast);
  assign pushEn   = !stb.flush && (packDone || stb.wrPush);
  assign pushData = stb.wrPush ? wrWord : packNext;
  assign popEn    = !stb.flush && (stb.rdPop || stb.wrLoad);

  always_ff @(posedge clk) begin
    if (pushEn) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (stb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (pushEn) wrPtr <= wrPtr + 1'b1;
      if (popEn)  rdPtr <= rdPtr + 1'b1;
      case ({pushEn, popEn})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      packReg <= '0;
      packIdx <= '0;
    end else if (stb.flush) begin
      packReg <= '0;
      packIdx <= '0;
    end else if (stb.rdAccept) begin
      if (packDone) begin
        packReg <= '0;
        packIdx <= '0;
      end else begin
        packReg <= packNext;
        packIdx <= packIdx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      unpWord <= '0;
      unpIdx  <= '0;
      unpCnt  <= '0;
    end else if (stb.flush) begin
      unpWord <= '0;
      unpIdx  <= '0;
      unpCnt  <= '0;
    end else if (stb.wrLoad) begin
      unpWord <= mem[rdPtr];
      unpIdx  <= '0;
      unpCnt  <= 3'd4;
    end else if (stb.wrTake) begin
      if (stb.wrLast) begin
        unpCnt <= '0;
      end else begin
        unpIdx <= unpIdx + 1'b1;
        unpCnt <= unpCnt - 1'b1;
      end
    end
  end

  assign headWord   = mem[rdPtr];
  assign fifoCount  = cnt;
  assign packCnt    = packIdx;
  assign unpackCnt  = unpCnt;
  assign unpackByte = unpWord[8*unpIdx +: 8];

  // R5 / R6: the control must never pop an empty FIFO
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> cnt != '0);
  // R6: the control must never push into a full FIFO
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !popEn) |-> cnt < DEPTH_C);
  // R5: the final byte always leaves the packer empty
  p_pack_empty_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdAccept && stb.rdLast && !stb.flush) |=> packIdx == 2'd0);
endmodule

// File: rtl/nand_xfer_ctrl.sv
`timescale 1ns/1ps
module nand_xfer_ctrl
  import nand_xfer_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 13,
  parameter int BURST_WORDS = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [2:0]     regAddr,
  input  logic           regWrEn,
  input  logic [31:0]    regWrData,
  output logic [31:0]    regRdData,
  input  logic           nandRdValid,
  output logic           nandRdReady,
  output logic           nandWrValid,
  input  logic           nandWrTake,
  input  logic           nandReady,
  output logic           dmaBurstReq,
  output logic           dmaSingleReq,
  input  logic           dmaRdPop,
  input  logic           dmaWrPush,
  input  logic [CW-1:0]  fifoCount,
  input  logic [1:0]     packCnt,
  input  logic [2:0]     unpackCnt,
  output xferStrobes_t   stb,
  output logic           eccClear,
  output logic           eccRun,
  output logic           irq
);
  localparam int CALC_W = CNT_W + CW + 3;
  localparam logic [CW-1:0]     DEPTH_C = CW'(DEPTH);
  localparam logic [CW-1:0]     BW_C    = CW'(BURST_WORDS);
  localparam logic [CALC_W-1:0] BB_C    = CALC_W'(BURST_WORDS * 4);
  localparam logic [CNT_W-1:0]  ONE_C   = CNT_W'(1);

  logic             startQ, dirQ, burstQ, eccDmaQ, readyQ, eccClrQ;
  logic [CNT_W-1:0] txCount;
  logic [1:0]       intEn, intRaw, intSet, intClr;
  logic             wrCtrl, wrCfg, wrEn, wrClr, wrCnt, softReset;
  logic             rdActive, wrActive, dec, tcEvent, readyEvent;
  logic [CALC_W-1:0] txExt, bufBytes, needBytes;
  logic [CW-1:0]    freeWords;
  logic             rdBurst, rdSingle, wrBurst, wrSingle;

  assign wrCtrl    = regWrEn && regAddr == A_CTRL;
  assign wrCfg     = regWrEn && regAddr == A_CFG;
  assign wrEn      = regWrEn && regAddr == A_IEN;
  assign wrClr     = regWrEn && regAddr == A_ICLR;
  assign wrCnt     = regWrEn && regAddr == A_TCNT;
  assign softReset = wrCtrl && regWrData[CTRL_SRST];

  assign rdActive = startQ && dirQ && txCount != '0;
  assign wrActive = startQ && !dirQ && txCount != '0;

  assign nandRdReady = rdActive && fifoCount < DEPTH_C;
  assign nandWrValid = wrActive && unpackCnt != '0;

  always_comb begin
    stb          = '0;
    stb.flush    = softReset;
    stb.rdAccept = nandRdValid && nandRdReady;
    stb.rdLast   = txCount == ONE_C;
    stb.rdPop    = dmaRdPop && dirQ && fifoCount != '0;
    stb.wrPush   = dmaWrPush && startQ && !dirQ && fifoCount < DEPTH_C;
    stb.wrLoad   = wrActive && unpackCnt == '0 && fifoCount != '0;
    stb.wrTake   = nandWrTake && nandWrValid;
    stb.wrLast   = txCount == ONE_C;
  end

  assign dec        = stb.rdAccept || stb.wrTake;
  assign tcEvent    = dec && startQ && txCount == ONE_C;
  assign readyEvent = nandReady && !readyQ;
  assign intSet     = {tcEvent, readyEvent};
  assign intClr     = wrClr ? regWrData[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= 1'b0;
      dirQ    <= 1'b0;
      burstQ  <= 1'b0;
      eccDmaQ <= 1'b0;
      txCount <= '0;
      intEn   <= '0;
      intRaw  <= '0;
      readyQ  <= 1'b0;
      eccClrQ <= 1'b0;
    end else begin
      readyQ  <= nandReady;
      eccClrQ <= wrCtrl && regWrData[CTRL_ECCCLR];
      if (softReset) begin
        startQ  <= 1'b0;
        dirQ    <= 1'b0;
        burstQ  <= 1'b0;
        eccDmaQ <= 1'b0;
        txCount <= '0;
        intEn   <= '0;
        intRaw  <= '0;
      end else begin
        if (wrCtrl) startQ <= regWrData[CTRL_START];
        if (wrCfg) begin
          dirQ    <= regWrData[CFG_DIR];
          burstQ  <= regWrData[CFG_BURST];
          eccDmaQ <= regWrData[CFG_ECCDMA];
        end
        if (wrEn) intEn <= regWrData[1:0];
        if (wrCnt)    txCount <= regWrData[CNT_W-1:0];
        else if (dec) txCount <= txCount - 1'b1;
        intRaw <= (intRaw & ~intClr) | intSet;
      end
    end
  end

  // request generation
  assign txExt     = CALC_W'(txCount);
  assign bufBytes  = CALC_W'({fifoCount, 2'b00}) + CALC_W'(unpackCnt);
  assign needBytes = (txExt > bufBytes) ? txExt - bufBytes : '0;
  assign freeWords = DEPTH_C - fifoCount;

  assign rdBurst  = startQ && dirQ && burstQ && fifoCount >= BW_C;
  assign rdSingle = startQ && dirQ && !rdBurst && fifoCount != '0 &&
                    (!burstQ || txExt < BB_C);
  assign wrBurst  = startQ && !dirQ && burstQ && freeWords >= BW_C &&
                    needBytes >= BB_C;
  assign wrSingle = startQ && !dirQ && !wrBurst && freeWords != '0 &&
                    needBytes != '0 && (!burstQ || needBytes < BB_C);

  assign dmaBurstReq  = rdBurst || wrBurst;
  assign dmaSingleReq = rdSingle || wrSingle;

  assign eccClear = eccClrQ;
  assign eccRun   = startQ && eccDmaQ;
  assign irq      = |(intRaw & intEn);

  always_comb begin
    regRdData = '0;
    case (regAddr)
      A_CTRL: regRdData[CTRL_START] = startQ;
      A_CFG: begin
        regRdData[CFG_DIR]    = dirQ;
        regRdData[CFG_BURST]  = burstQ;
        regRdData[CFG_ECCDMA] = eccDmaQ;
      end
      A_STAT: begin
        regRdData[ST_DFIFO] = fifoCount != '0;
        regRdData[ST_CFIFO] = packCnt != '0 || unpackCnt != '0;
        regRdData[ST_READY] = readyQ;
      end
      A_IRAW: regRdData[1:0] = intRaw;
      A_IEN:  regRdData[1:0] = intEn;
      A_IMSK: regRdData[1:0] = intRaw & intEn;
      A_TCNT: regRdData[CNT_W-1:0] = txCount;
      default: regRdData = '0;
    endcase
  end

  // R4: the count only moves down unless software loads it
  p_count_down_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrCnt) |-> txCount <= $past(txCount));
  // R10: last byte moved latches the terminal count
  p_tc_latch_r10: assert property (@(posedge clk) disable iff (!rstN)
    (startQ && txCount == ONE_C && (stb.rdAccept || stb.wrTake) && !softReset)
      |=> intRaw[INT_TC]);
  // R11: a rising ready line latches the ready bit
  p_ready_latch_r11: assert property (@(posedge clk) disable iff (!rstN)
    (nandReady && !readyQ && !softReset) |=> intRaw[INT_RDY]);
  // R8: never both request kinds at once
  p_req_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dmaBurstReq, dmaSingleReq}));
  // R13: software reset leaves the unit idle and the FIFO empty
  p_sreset_idle_r13: assert property (@(posedge clk) disable iff (!rstN)
    softReset |=> (txCount == '0 && intRaw == '0 && intEn == '0 &&
                   !startQ && fifoCount == '0));
endmodule

// File: rtl/nand_xfer_unit.sv
`timescale 1ns/1ps
module nand_xfer_unit
  import nand_xfer_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = 13,
  parameter int BURST_WORDS = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  regAddr,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        nandRdValid,
  input  logic [7:0]  nandRdByte,
  output logic        nandRdReady,
  output logic        nandWrValid,
  output logic [7:0]  nandWrByte,
  input  logic        nandWrTake,
  input  logic        nandReady,
  output logic        dmaBurstReq,
  output logic        dmaSingleReq,
  input  logic        dmaRdPop,
  output logic [31:0] dmaRdData,
  input  logic        dmaWrPush,
  input  logic [31:0] dmaWrData,
  output logic        eccClear,
  output logic        eccRun,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH + 1);

  xferStrobes_t  stb;
  logic [CW-1:0] fifoCount;
  logic [1:0]    packCnt;
  logic [2:0]    unpackCnt;

  nand_xfer_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W), .BURST_WORDS(BURST_WORDS)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .nandRdValid(nandRdValid), .nandRdReady(nandRdReady),
    .nandWrValid(nandWrValid), .nandWrTake(nandWrTake), .nandReady(nandReady),
    .dmaBurstReq(dmaBurstReq), .dmaSingleReq(dmaSingleReq),
    .dmaRdPop(dmaRdPop), .dmaWrPush(dmaWrPush),
    .fifoCount(fifoCount), .packCnt(packCnt), .unpackCnt(unpackCnt),
    .stb(stb), .eccClear(eccClear), .eccRun(eccRun), .irq(irq)
  );

  nand_xfer_datapath #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb),
    .rdByte(nandRdByte), .wrWord(dmaWrData), .headWord(dmaRdData),
    .fifoCount(fifoCount), .packCnt(packCnt), .unpackCnt(unpackCnt),
    .unpackByte(nandWrByte)
  );
endmodule

// File: tb/nand_xfer_unit_tb_top.sv
`timescale 1ns/1ps
module nand_xfer_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        nandRdValid = 1'b0;
  logic [7:0]  nandRdByte = '0;
  logic        nandRdReady;
  logic        nandWrValid;
  logic [7:0]  nandWrByte;
  logic        nandWrTake = 1'b0;
  logic        nandReady = 1'b0;
  logic        dmaBurstReq, dmaSingleReq;
  logic        dmaRdPop = 1'b0;
  logic [31:0] dmaRdData;
  logic        dmaWrPush = 1'b0;
  logic [31:0] dmaWrData = '0;
  logic        eccClear, eccRun, irq;

  int nChecks = 0;
  int nFails = 0;
  logic [31:0] expWords[$];
  logic [7:0]  expBytes[$];
  logic [31:0] asm;
  int          asmN;

  always #2.5 clk = ~clk;

  nand_xfer_unit dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regCheck(input logic [2:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #0.1;
    check(req, regRdData, exp);
  endtask

  // driver: offer one flash byte and record the expected word
  task automatic feedByte(input logic [7:0] b, input bit last);
    @(negedge clk);
    check("R4 rd ready", {31'b0, nandRdReady}, 32'd1);
    nandRdValid = 1'b1; nandRdByte = b;
    asm[8*asmN +: 8] = b; asmN++;
    if (asmN == 4 || last) begin expWords.push_back(asm); asm = '0; asmN = 0; end
    @(negedge clk);
    nandRdValid = 1'b0;
  endtask

  // monitor: compare the head word with the scoreboard, then pop
  task automatic popWord();
    logic [31:0] e;
    e = expWords.pop_front();
    check("R5 word", dmaRdData, e);
    dmaRdPop = 1'b1;
    @(negedge clk);
    dmaRdPop = 1'b0;
  endtask

  task automatic pushWord(input logic [31:0] w);
    @(negedge clk);
    dmaWrPush = 1'b1; dmaWrData = w;
    @(negedge clk);
    dmaWrPush = 1'b0;
  endtask

  task automatic takeByte();
    logic [7:0] e;
    int waitN = 0;
    while (!nandWrValid && waitN < 20) begin @(negedge clk); waitN++; end
    e = expBytes.pop_front();
    check("R6 byte", {24'b0, nandWrByte}, {24'b0, e});
    nandWrTake = 1'b1;
    @(negedge clk);
    nandWrTake = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    asm = '0; asmN = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 8; a++) regCheck(3'(a), 32'h0, "R1 reg");
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 req", {30'b0, dmaBurstReq, dmaSingleReq}, 0);
    check("R1 eccClear", {31'b0, eccClear}, 0);

    // R11 / R12 ready interrupt
    regWrite(3'd4, 32'h3);
    regCheck(3'd4, 32'h3, "R12 enable");
    nandReady = 1'b1;
    @(negedge clk); @(negedge clk);
    regCheck(3'd3, 32'h1, "R11 ready latched");
    regCheck(3'd5, 32'h1, "R12 masked");
    check("R12 irq on", {31'b0, irq}, 1);
    regWrite(3'd4, 32'h2);
    regCheck(3'd5, 32'h0, "R12 masked off");
    check("R12 irq masked", {31'b0, irq}, 0);
    regWrite(3'd6, 32'h1);
    regCheck(3'd3, 32'h0, "R12 w1c");
    regWrite(3'd4, 32'h3);

    // read transfer, burst on, 22 bytes
    regWrite(3'd1, 32'h6);
    regCheck(3'd1, 32'h6, "R3 cfg readback");
    regWrite(3'd7, 32'd22);
    regWrite(3'd0, 32'h1);
    regCheck(3'd0, 32'h1, "R2 start readback");
    for (int i = 0; i < 5; i++) feedByte(8'(8'h10 + i), 1'b0);
    regCheck(3'd2, 32'h7, "R9 status mid read");
    check("R8 no single in burst", {31'b0, dmaSingleReq}, 0);
    for (int i = 5; i < 16; i++) feedByte(8'(8'h10 + i), 1'b0);
    check("R7 burst read", {31'b0, dmaBurstReq}, 1);
    regCheck(3'd7, 32'd6, "R4 count");
    for (int i = 16; i < 22; i++) feedByte(8'(8'h10 + i), i == 21);
    regCheck(3'd7, 32'd0, "R4 count zero");
    check("R4 no more accept", {31'b0, nandRdReady}, 0);
    regCheck(3'd3, 32'h2, "R10 tc latched");
    check("R10 irq", {31'b0, irq}, 1);
    for (int i = 0; i < 4; i++) popWord();
    check("R8 single tail", {30'b0, dmaBurstReq, dmaSingleReq}, 32'h1);
    popWord(); popWord();
    regCheck(3'd2, 32'h1, "R9 status drained");
    regWrite(3'd6, 32'h2);
    regCheck(3'd3, 32'h0, "R12 tc cleared");

    // write transfer, burst off, 6 bytes, ECC enabled
    regWrite(3'd0, 32'h0);
    regWrite(3'd1, 32'h10);
    regCheck(3'd1, 32'h10, "R3 ecc bit");
    regWrite(3'd7, 32'd6);
    regWrite(3'd0, 32'h3);
    check("R2 ecc pulse", {31'b0, eccClear}, 1);
    check("R3 eccRun", {31'b0, eccRun}, 1);
    check("R8 single write", {30'b0, dmaBurstReq, dmaSingleReq}, 32'h1);
    @(negedge clk);
    check("R2 ecc pulse end", {31'b0, eccClear}, 0);
    regCheck(3'd0, 32'h1, "R2 pulse bits read 0");
    for (int i = 1; i <= 8; i++) if (i <= 6) expBytes.push_back(8'(8'h11 * i));
    pushWord(32'h44332211);
    check("R8 single still", {31'b0, dmaSingleReq}, 1);
    pushWord(32'h88776655);
    check("R8 single done", {31'b0, dmaSingleReq}, 0);
    for (int i = 0; i < 6; i++) takeByte();
    regCheck(3'd7, 32'd0, "R4 write count zero");
    check("R6 no more bytes", {31'b0, nandWrValid}, 0);
    regCheck(3'd2, 32'h1, "R6 leftover discarded");
    regCheck(3'd3, 32'h2, "R10 tc on write");

    // burst write then software reset
    regWrite(3'd6, 32'h3);
    regWrite(3'd0, 32'h0);
    regWrite(3'd1, 32'h4);
    regWrite(3'd7, 32'd20);
    regWrite(3'd0, 32'h1);
    check("R7 burst write", {30'b0, dmaBurstReq, dmaSingleReq}, 32'h2);
    pushWord(32'hA0A1A2A3);
    check("R7 burst write 16 left", {31'b0, dmaBurstReq}, 1);
    pushWord(32'hB0B1B2B3);
    check("R8 single 12 left", {30'b0, dmaBurstReq, dmaSingleReq}, 32'h1);
    regWrite(3'd0, 32'h5);
    regCheck(3'd0, 32'h0, "R13 start");
    regCheck(3'd1, 32'h0, "R13 cfg");
    regCheck(3'd4, 32'h0, "R13 enable");
    regCheck(3'd7, 32'h0, "R13 count");
    regCheck(3'd2, 32'h1, "R13 fifo empty");
    regCheck(3'd3, 32'h0, "R13 raw");
    check("R13 req", {30'b0, dmaBurstReq, dmaSingleReq}, 0);
    check("R13 irq", {31'b0, irq}, 0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule